// File: doc/BRIEF.md
# Generic Address Window Splitter

This block sits at the front of a vector load unit. Each instruction brings a lane address per lane, an active-lane mask and a load kind. A load of kind shared, local or global names its window outright and is passed downstream at once as a single request covering every active lane.

A generic load does not name a window. The block first spends one cycle sorting every active lane into the shared, local or global window. Two programmable address ranges, each a base and a limit, define the shared and local windows. Any address that falls in neither range is global. The block then emits one sub-request for each window that owns at least one active lane. The sub-requests go out in a fixed order, and each carries its window code and the lanes that belong to it.

The input stays blocked until the final sub-request of the current instruction has been taken downstream. An instruction with no active lanes is consumed in one cycle and produces nothing.

Top module: `lane_window_splitter`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: A lane address `a` belongs to the shared window when `shm_base <= a < shm_limit`. Otherwise it belongs to the local window when `lcl_base <= a < lcl_limit`. Any other address is global. Where the two ranges overlap, shared wins.
- R3: A generic load (`in_kind` = 00) with a nonzero mask spends one classification cycle. `out_valid` is 0 in the cycle right after acceptance and is 1 in the cycle after that.
- R4: An explicit load (`in_kind` 01 shared, 10 local, 11 global) with a nonzero mask raises `out_valid` in the cycle right after acceptance. It issues exactly one request, whose `out_win` equals `in_kind`, whose `out_mask` equals `in_mask`, and whose `out_last` is 1.
- R5: The requests of a generic load are issued in the order shared, then local, then global. A window with no active lanes is skipped.
- R6: The masks of one generic load's requests are nonzero and disjoint, and together they equal the active mask. `out_last` is 1 on the final request only.
- R7: `in_ready` is 0 from the acceptance of a load with active lanes until the final request is accepted (`out_valid && out_ready && out_last`). It is 1 in the cycle after that.
- R8: A load with an all-zero `in_mask` is accepted without issuing any request, and `in_ready` stays 1 in the next cycle.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_win`, `out_mask` and `out_last` hold steady into the next cycle.
- R10: Window codes on `out_win` are 01 shared, 10 local and 11 global. The code 00 never appears while `out_valid` is 1.
- R11: The addresses of inactive lanes have no effect on the requests produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Block can take an instruction |
| in_kind | input | 2 | 00 generic, 01 shared, 10 local, 11 global |
| in_mask | input | LANES | Active-lane mask |
| in_addr | input | LANES*AW | Lane addresses, lane i at bits [i*AW +: AW] |
| shm_base | input | AW | Shared window base (inclusive) |
| shm_limit | input | AW | Shared window limit (exclusive) |
| lcl_base | input | AW | Local window base (inclusive) |
| lcl_limit | input | AW | Local window limit (exclusive) |
| out_valid | output | 1 | Request present |
| out_ready | input | 1 | Downstream takes the request |
| out_win | output | 2 | Window code of the request |
| out_mask | output | LANES | Lanes served by the request |
| out_last | output | 1 | Final request of the instruction |

## Verification
Downstream back-pressure and the advance to the next request can fall in the same cycle. When `out_ready` drops while a multi-window generic load is mid-sequence, the block must hold the current request and must not skip ahead to the next window. The bench drives `out_ready` from a pseudo-random stall pattern across many mixed-window generic loads. A scoreboard that pops one expected request per accepted handshake then judges order, masks and last flags, and the `out_ready`-low cycles are checked for a held request.

// File: rtl/win_split_pkg.sv
package win_split_pkg;
   typedef enum logic [1:0] {
      WIN_NONE = 2'b00,
      WIN_SHM  = 2'b01,
      WIN_LCL  = 2'b10,
      WIN_GLB  = 2'b11
   } win_e;

   localparam logic [1:0] KIND_GENERIC = 2'b00;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'b00,
      ST_CLASS = 2'b01,
      ST_ISSUE = 2'b10
   } split_st_e;
endpackage

// File: rtl/lane_classify.sv
module lane_classify
   import win_split_pkg::*;
#(
   parameter int AW              = 32,
   parameter bit LIMIT_INCLUSIVE = 1'b0
) (
   input  logic [AW-1:0] addr,
   input  logic [AW-1:0] shm_base,
   input  logic [AW-1:0] shm_limit,
   input  logic [AW-1:0] lcl_base,
   input  logic [AW-1:0] lcl_limit,
   output win_e          win
);
   logic hit_shm, hit_lcl;

   generate
      if (LIMIT_INCLUSIVE) begin : g_incl
         assign hit_shm = (addr >= shm_base) && (addr <= shm_limit);
         assign hit_lcl = (addr >= lcl_base) && (addr <= lcl_limit);
      end else begin : g_excl
         assign hit_shm = (addr >= shm_base) && (addr < shm_limit);
         assign hit_lcl = (addr >= lcl_base) && (addr < lcl_limit);
      end
   endgenerate

   always_comb begin
      if (hit_shm)      win = WIN_SHM;
      else if (hit_lcl) win = WIN_LCL;
      else              win = WIN_GLB;
   end
endmodule

// File: rtl/window_masks.sv
module window_masks
   import win_split_pkg::*;
#(
   parameter int LANES           = 8,
   parameter int AW              = 32,
   parameter bit LIMIT_INCLUSIVE = 1'b0
) (
   input  logic [LANES*AW-1:0] addr,
   input  logic [LANES-1:0]    active,
   input  logic [AW-1:0]       shm_base,
   input  logic [AW-1:0]       shm_limit,
   input  logic [AW-1:0]       lcl_base,
   input  logic [AW-1:0]       lcl_limit,
   output logic [LANES-1:0]    m_shm,
   output logic [LANES-1:0]    m_lcl,
   output logic [LANES-1:0]    m_glb
);
   generate
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         win_e lw;
         lane_classify #(.AW(AW), .LIMIT_INCLUSIVE(LIMIT_INCLUSIVE)) u_cls (
            .addr      (addr[i*AW +: AW]),
            .shm_base  (shm_base),
            .shm_limit (shm_limit),
            .lcl_base  (lcl_base),
            .lcl_limit (lcl_limit),
            .win       (lw)
         );
         assign m_shm[i] = active[i] && (lw == WIN_SHM);
         assign m_lcl[i] = active[i] && (lw == WIN_LCL);
         assign m_glb[i] = active[i] && (lw == WIN_GLB);
      end
   endgenerate
endmodule

// File: rtl/pass_pick.sv
module pass_pick
   import win_split_pkg::*;
#(
   parameter int LANES = 8
) (
   input  logic [LANES-1:0] p_shm,
   input  logic [LANES-1:0] p_lcl,
   input  logic [LANES-1:0] p_glb,
   output win_e             win,
   output logic [LANES-1:0] mask,
   output logic             last
);
   always_comb begin
      win  = WIN_NONE;
      mask = '0;
      last = 1'b0;
      if (|p_shm) begin
         win  = WIN_SHM;
         mask = p_shm;
         last = ~|{p_lcl, p_glb};
      end else if (|p_lcl) begin
         win  = WIN_LCL;
         mask = p_lcl;
         last = ~|p_glb;
      end else if (|p_glb) begin
         win  = WIN_GLB;
         mask = p_glb;
         last = 1'b1;
      end
   end
endmodule

// File: rtl/lane_window_splitter.sv
module lane_window_splitter
   import win_split_pkg::*;
#(
   parameter int LANES           = 8,
   parameter int AW              = 32,
   parameter bit LIMIT_INCLUSIVE = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   output logic                in_ready,
   input  logic [1:0]          in_kind,
   input  logic [LANES-1:0]    in_mask,
   input  logic [LANES*AW-1:0] in_addr,
   input  logic [AW-1:0]       shm_base,
   input  logic [AW-1:0]       shm_limit,
   input  logic [AW-1:0]       lcl_base,
   input  logic [AW-1:0]       lcl_limit,
   output logic                out_valid,
   input  logic                out_ready,
   output logic [1:0]          out_win,
   output logic [LANES-1:0]    out_mask,
   output logic                out_last
);
   localparam int ADDR_BITS = LANES * AW;

   generate
      if (LANES < 1) begin : g_bad_lanes
         $error("lane_window_splitter: LANES must be at least 1");
      end
      if (AW < 2) begin : g_bad_aw
         $error("lane_window_splitter: AW must be at least 2");
      end
   endgenerate

   split_st_e              st_q;
   logic [ADDR_BITS-1:0]   addr_q;
   logic [LANES-1:0]       act_q;
   logic [LANES-1:0]       pend_shm_q, pend_lcl_q, pend_glb_q;
   logic [LANES-1:0]       cls_shm, cls_lcl, cls_glb;
   win_e                   pick_win;
   logic [LANES-1:0]       pick_mask;
   logic                   pick_last;
   logic                   take_in, take_out;

   window_masks #(.LANES(LANES), .AW(AW), .LIMIT_INCLUSIVE(LIMIT_INCLUSIVE)) u_masks (
      .addr      (addr_q),
      .active    (act_q),
      .shm_base  (shm_base),
      .shm_limit (shm_limit),
      .lcl_base  (lcl_base),
      .lcl_limit (lcl_limit),
      .m_shm     (cls_shm),
      .m_lcl     (cls_lcl),
      .m_glb     (cls_glb)
   );

   pass_pick #(.LANES(LANES)) u_pick (
      .p_shm (pend_shm_q),
      .p_lcl (pend_lcl_q),
      .p_glb (pend_glb_q),
      .win   (pick_win),
      .mask  (pick_mask),
      .last  (pick_last)
   );

   assign in_ready  = (st_q == ST_IDLE);
   assign out_valid = (st_q == ST_ISSUE);
   assign out_win   = pick_win;
   assign out_mask  = pick_mask;
   assign out_last  = pick_last;
   assign take_in   = in_valid && in_ready;
   assign take_out  = out_valid && out_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         addr_q     <= '0;
         act_q      <= '0;
         pend_shm_q <= '0;
         pend_lcl_q <= '0;
         pend_glb_q <= '0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (take_in && (|in_mask)) begin
                  if (in_kind == KIND_GENERIC) begin
                     addr_q <= in_addr;
                     act_q  <= in_mask;
                     st_q   <= ST_CLASS;
                  end else begin
                     pend_shm_q <= (in_kind == WIN_SHM) ? in_mask : '0;
                     pend_lcl_q <= (in_kind == WIN_LCL) ? in_mask : '0;
                     pend_glb_q <= (in_kind == WIN_GLB) ? in_mask : '0;
                     st_q       <= ST_ISSUE;
                  end
               end
            end
            ST_CLASS: begin
               pend_shm_q <= cls_shm;
               pend_lcl_q <= cls_lcl;
               pend_glb_q <= cls_glb;
               st_q       <= ST_ISSUE;
            end
            ST_ISSUE: begin
               if (take_out) begin
                  case (pick_win)
                     WIN_SHM: pend_shm_q <= '0;
                     WIN_LCL: pend_lcl_q <= '0;
                     WIN_GLB: pend_glb_q <= '0;
                     default: ;
                  endcase
                  if (pick_last) st_q <= ST_IDLE;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/lane_window_splitter_chk.sv
module lane_window_splitter_chk #(
   parameter int LANES = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             in_ready,
   input logic [1:0]       in_kind,
   input logic [LANES-1:0] in_mask,
   input logic             out_valid,
   input logic             out_ready,
   input logic [1:0]       out_win,
   input logic [LANES-1:0] out_mask,
   input logic             out_last
);
   // R9: request held under back-pressure
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_win) && $stable(out_mask) && $stable(out_last));

   // R10: no null window code on a valid request
   a_r10_code: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_win != 2'b00);

   // R6: every request serves at least one lane
   a_r6_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_mask != '0);

   // R7: input blocked while requests are outstanding
   a_r7_busy: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !in_ready);

   // R7: input reopens after the final request is taken
   a_r7_reopen: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_ready && out_last |=> in_ready && !out_valid);

   // R4: explicit load issues one full request next cycle
   a_r4_explicit: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready && in_kind != 2'b00 && in_mask != '0 |=>
         out_valid && out_last && out_win == $past(in_kind) && out_mask == $past(in_mask));

   // R3: generic load spends one classification cycle
   a_r3_class_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready && in_kind == 2'b00 && in_mask != '0 |=> !out_valid ##1 out_valid);

   // R8: empty load leaves the block idle
   a_r8_empty: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready && in_mask == '0 |=> in_ready && !out_valid);

   // R5: window codes strictly rise within one instruction
   a_r5_order: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_ready && !out_last |=> out_valid && out_win > $past(out_win));
endmodule

bind lane_window_splitter lane_window_splitter_chk #(.LANES(LANES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .in_kind   (in_kind),
   .in_mask   (in_mask),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_win   (out_win),
   .out_mask  (out_mask),
   .out_last  (out_last)
);

// File: tb/sim_lane_window_splitter.sv
module sim_lane_window_splitter;
   localparam int LANES = 8;
   localparam int AW    = 32;
   localparam int CLK_PERIOD = 10;
   localparam int ITEM_W = LANES + 3;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                in_valid = 1'b0;
   logic                in_ready;
   logic [1:0]          in_kind = 2'b00;
   logic [LANES-1:0]    in_mask = '0;
   logic [LANES*AW-1:0] in_addr = '0;
   logic [AW-1:0]       shm_base  = 32'h0000_1000;
   logic [AW-1:0]       shm_limit = 32'h0000_2000;
   logic [AW-1:0]       lcl_base  = 32'h0000_8000;
   logic [AW-1:0]       lcl_limit = 32'h0000_C000;
   logic                out_valid;
   logic                out_ready = 1'b1;
   logic [1:0]          out_win;
   logic [LANES-1:0]    out_mask;
   logic                out_last;

   int total = 0;
   int bad = 0;
   bit stall_on = 1'b0;
   bit expect_reopen = 1'b0;
   logic [ITEM_W-1:0] expq [$];

   always #(CLK_PERIOD/2) clk = ~clk;

   lane_window_splitter #(.LANES(LANES), .AW(AW)) u0 (
      .clk, .rst_n, .in_valid, .in_ready, .in_kind, .in_mask, .in_addr,
      .shm_base, .shm_limit, .lcl_base, .lcl_limit,
      .out_valid, .out_ready, .out_win, .out_mask, .out_last
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   function automatic logic [1:0] ref_win(input logic [AW-1:0] a);
      if (a >= shm_base && a < shm_limit) return 2'b01;
      if (a >= lcl_base && a < lcl_limit) return 2'b10;
      return 2'b11;
   endfunction

   // Driver: computes expected requests, pushes them, then presents the load
   task automatic send(input logic [1:0] kind, input logic [LANES-1:0] m,
                       input logic [LANES*AW-1:0] av);
      logic [LANES-1:0] wm [1:3];
      int last_w = 0;
      for (int w = 1; w <= 3; w++) wm[w] = '0;
      if (kind == 2'b00) begin
         for (int i = 0; i < LANES; i++)
            if (m[i]) wm[ref_win(av[i*AW +: AW])][i] = 1'b1;
      end else if (m != '0) begin
         wm[kind] = m;
      end
      for (int w = 1; w <= 3; w++) if (wm[w] != '0) last_w = w;
      for (int w = 1; w <= 3; w++)
         if (wm[w] != '0) expq.push_back({w[1:0], wm[w], (w == last_w)});

      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1; in_kind = kind; in_mask = m; in_addr = av;
      @(posedge clk);
      #1 in_valid = 1'b0;
      @(negedge clk);
      if (m == '0) begin
         check(in_ready && !out_valid, "R8", "idle after empty load",
               {30'd0, in_ready, out_valid}, 32'h2);
      end else if (kind == 2'b00) begin
         check(!out_valid, "R3", "no request in classification cycle", out_valid, 0);
         @(negedge clk);
         check(out_valid, "R3", "request after classification cycle", out_valid, 1);
      end else begin
         check(out_valid, "R4", "explicit request next cycle", out_valid, 1);
      end
      while (expq.size() != 0 || !in_ready) @(negedge clk);
   endtask

   // Monitor: one expected item per accepted handshake
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (expect_reopen) begin
               check(in_ready && !out_valid, "R7", "input reopens after last",
                     {30'd0, in_ready, out_valid}, 32'h2);
               expect_reopen = 1'b0;
            end
            if (out_valid && in_ready)
               check(1'b0, "R7", "ready while busy", in_ready, 0);
            if (out_valid && out_ready) begin
               if (expq.size() == 0) begin
                  check(1'b0, "R5", "unexpected request", {out_win, out_mask, out_last}, 0);
               end else begin
                  logic [ITEM_W-1:0] e;
                  e = expq.pop_front();
                  check({out_win, out_mask, out_last} == e, "R5/R6",
                        "request win/mask/last", {out_win, out_mask, out_last}, e);
                  if (out_last) expect_reopen = 1'b1;
               end
            end
         end
      end
   end

   // Back-pressure pattern
   initial begin
      forever begin
         @(posedge clk);
         #1 out_ready = stall_on ? (($urandom % 3) != 0) : 1'b1;
      end
   end

   // R9: held request under stall, checked at the ports
   initial begin
      logic [ITEM_W-1:0] prev;
      bit was_stalled = 1'b0;
      forever begin
         @(negedge clk);
         if (was_stalled && rst_n)
            check(out_valid && {out_win, out_mask, out_last} == prev, "R9",
                  "request held under stall", {out_win, out_mask, out_last}, prev);
         was_stalled = rst_n && out_valid && !out_ready;
         prev = {out_win, out_mask, out_last};
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   function automatic logic [LANES*AW-1:0] fill(input logic [AW-1:0] a);
      logic [LANES*AW-1:0] v;
      for (int i = 0; i < LANES; i++) v[i*AW +: AW] = a + AW'(i * 4);
      return v;
   endfunction

   function automatic logic [AW-1:0] pick_addr();
      case ($urandom % 6)
         0: return 32'h1000 + ($urandom % 32'h1000);
         1: return 32'h8000 + ($urandom % 32'h4000);
         2: return $urandom % 32'h1000;
         3: return 32'h1FFF + ($urandom % 2);
         4: return 32'hBFFF + ($urandom % 2);
         default: return $urandom;
      endcase
   endfunction

   initial begin
      logic [LANES*AW-1:0] av;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(!out_valid, "R1", "out_valid after reset", out_valid, 0);
      check(in_ready, "R1", "in_ready after reset", in_ready, 1);
      #1 rst_n = 1'b1;
      @(negedge clk);
      check(!out_valid && in_ready, "R1", "idle after reset release",
            {30'd0, in_ready, out_valid}, 32'h2);

      // R4 / R10: explicit kinds 01, 10, 11
      send(2'b01, 8'hA5, fill(32'h0000_0000));
      send(2'b10, 8'hFF, fill(32'h0000_1000));
      send(2'b11, 8'h01, fill(32'h0000_8000));

      // R8: empty masks, generic and explicit
      send(2'b00, 8'h00, fill(32'h0000_1000));
      send(2'b10, 8'h00, fill(32'h0000_1000));

      // R2: single-window generic loads
      send(2'b00, 8'hFF, fill(32'h0000_1100));
      send(2'b00, 8'hF0, fill(32'h0000_9000));
      send(2'b00, 8'h3C, fill(32'h0004_0000));

      // R5: all three windows, lanes interleaved
      for (int i = 0; i < LANES; i++)
         av[i*AW +: AW] = (i % 3 == 0) ? 32'h1200 : (i % 3 == 1) ? 32'h8800 : 32'h7000;
      send(2'b00, 8'hFF, av);
      // R5: shared and global only, local skipped
      for (int i = 0; i < LANES; i++)
         av[i*AW +: AW] = i[0] ? 32'h1800 : 32'hF000_0000;
      send(2'b00, 8'hFF, av);

      // R2 boundaries: base in, limit out
      av = fill(32'h0);
      av[0*AW +: AW] = 32'h1000; av[1*AW +: AW] = 32'h1FFF;
      av[2*AW +: AW] = 32'h2000; av[3*AW +: AW] = 32'h0FFF;
      av[4*AW +: AW] = 32'h8000; av[5*AW +: AW] = 32'hBFFF;
      av[6*AW +: AW] = 32'hC000; av[7*AW +: AW] = 32'h7FFF;
      send(2'b00, 8'hFF, av);

      // R11: inactive lanes carry shared/local addresses, active lanes global
      for (int i = 0; i < LANES; i++)
         av[i*AW +: AW] = (i < 4) ? 32'h5000 : (i[0] ? 32'h1400 : 32'h9000);
      send(2'b00, 8'h0F, av);

      // R2: overlapping windows, shared takes precedence
      lcl_base = 32'h1800; lcl_limit = 32'h3000;
      for (int i = 0; i < LANES; i++)
         av[i*AW +: AW] = (i < 3) ? 32'h1900 : (i < 6) ? 32'h2800 : 32'h0;
      send(2'b00, 8'hFF, av);
      lcl_base = 32'h8000; lcl_limit = 32'hC000;

      // R9 / R5 / R6: random generic and explicit loads under back-pressure
      stall_on = 1'b1;
      for (int n = 0; n < 60; n++) begin
         for (int i = 0; i < LANES; i++) av[i*AW +: AW] = pick_addr();
         send((n % 5 == 4) ? 2'($urandom % 4) : 2'b00, LANES'($urandom), av);
      end
      stall_on = 1'b0;

      repeat (4) @(negedge clk);
      check(expq.size() == 0, "R6", "all expected requests seen", expq.size(), 0);
      finish_run();
   end
endmodule